// File: doc/BRIEF.md
# Watchdog Wake-Up Reset Sequencer

This block keeps a sleeping microcontroller under supervision. It drives a periodic wake-up square wave that brings the processor out of its low-power state. In every wake-up cycle the processor must answer with a falling edge on the watchdog input. The first answer within a cycle pulls the wake-up line low straight away. It stays low until the next cycle starts. If a whole cycle passes with no answer, the block issues an active-low reset pulse when that cycle ends.

The reset output is also held low while the supply-good flag from an external comparator is deasserted. After the supply returns, reset is released one reset-pulse time later. A fixed restart delay then passes before the wake-up wave starts again with a rising edge. All intervals are counted in ticks from one shared prescaler. The base unit gives the reset pulse, four units give the restart delay, and eight units give the wake-up period.

Top module: `wakeWatchdogSeq`

## Requirements
- R1: While the power-on reset is asserted, and afterwards until the supply-good flag is first seen high, both the reset output and the wake-up output are low.
- R2: A clock edge that samples the supply-good flag low drives both outputs low after that edge, whatever phase is running. The block then waits in the held-in-reset state.
- R3: When the block leaves the held state, the reset output rises exactly UNIT_TICKS*TICK_DIV clocks after the first edge that samples the supply-good flag high.
- R4: After the reset output rises, the wake-up output rises exactly 4*UNIT_TICKS*TICK_DIV clocks later.
- R5: A wake-up cycle lasts 8*UNIT_TICKS*TICK_DIV clocks. If no watchdog falling edge arrives during the high half, the wake-up output is high for the first half of the cycle and low for the second half. A serviced cycle is followed at once by the next cycle, which starts with a rising edge.
- R6: The first falling edge on the watchdog input within a cycle drives the wake-up output low at the third rising clock edge after the input changes. This delay is two synchronizer stages plus the output register.
- R7: Further watchdog falling edges within the same cycle have no effect: the wake-up output stays low until the cycle ends.
- R8: A cycle that ends with no watchdog falling edge drives the reset output low at the cycle's last edge. The low pulse lasts UNIT_TICKS*TICK_DIV clocks and is followed by the restart delay of R4.
- R9: Watchdog falling edges during the reset pulse or the restart delay do not count toward the following cycle.
- R10: The wake-up output is low whenever the reset output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| supplyOk | input | 1 | Supply-good flag from the comparator, synchronous to clk |
| wdIn | input | 1 | Watchdog input from the processor, asynchronous |
| wakeOut | output | 1 | Wake-up square wave, registered |
| rstOutN | output | 1 | Reset output to the processor, active low, registered |

## Verification
A supply change reaches the outputs at the next clock edge. A watchdog edge reaches the wake-up output at the third edge after the input changes. Phase ends fall a whole number of prescaler periods after the phase starts. The bench runs a clock-by-clock reference model, which counts plain clocks rather than ticks, and compares both outputs with it at every falling clock edge. The directed cases count falling edges from an observed output transition to the exact edge where the next change is due. They also sample one edge before that edge, so an early change and a late change are both caught.

// File: rtl/wws_pkg.sv
package wws_pkg;

  typedef enum logic [1:0] {
    PH_HOLD    = 2'd0,
    PH_PULSE   = 2'd1,
    PH_RESTART = 2'd2,
    PH_CYCLE   = 2'd3
  } phase_t;

  typedef struct packed {
    logic clrTimer;
    logic clrService;
    logic armService;
  } dpStrobe_t;

  localparam int PULSE_UNITS   = 1;
  localparam int RESTART_UNITS = 4;
  localparam int CYCLE_UNITS   = 8;

endpackage

// File: rtl/wws_datapath.sv
module wws_datapath
  import wws_pkg::*;
#(
  parameter int TICK_DIV   = 1000,
  parameter int UNIT_TICKS = 5,
  localparam int CNT_W     = $clog2(CYCLE_UNITS * UNIT_TICKS)
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             wdIn,
  input  dpStrobe_t        strobe,
  output logic             tick,
  output logic [CNT_W-1:0] count,
  output logic             wdFall,
  output logic             serviced
);

  logic [2:0] wdSync;

  generate
    if (TICK_DIV <= 1) begin : g_noPrescale
      assign tick = 1'b1;
    end else begin : g_prescale
      localparam int PW = $clog2(TICK_DIV);
      localparam logic [PW-1:0] PLAST = PW'(TICK_DIV - 1);
      logic [PW-1:0] presc;
      always_ff @(posedge clk or negedge porN) begin
        if (!porN)                presc <= '0;
        else if (strobe.clrTimer) presc <= '0;
        else if (presc == PLAST)  presc <= '0;
        else                      presc <= presc + 1'b1;
      end
      assign tick = (presc == PLAST);
    end
  endgenerate

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                count <= '0;
    else if (strobe.clrTimer) count <= '0;
    else if (tick)            count <= count + 1'b1;
  end

  // two synchronizer stages, third stage keeps the previous value for edge detection
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) wdSync <= 3'b111;
    else       wdSync <= {wdSync[1:0], wdIn};
  end

  assign wdFall = wdSync[2] & ~wdSync[1];

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                           serviced <= 1'b0;
    else if (strobe.clrService)          serviced <= 1'b0;
    else if (strobe.armService && wdFall) serviced <= 1'b1;
  end

endmodule

// File: rtl/wws_control.sv
module wws_control
  import wws_pkg::*;
#(
  parameter int TICK_DIV   = 1000,
  parameter int UNIT_TICKS = 5,
  localparam int CNT_W     = $clog2(CYCLE_UNITS * UNIT_TICKS)
) (
  input  logic             clk,
  input  logic             porN,
  input  logic             supplyOk,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             wdFall,
  input  logic             serviced,
  output dpStrobe_t        strobe,
  output logic             rstOutN,
  output logic             wakeOut
);

  localparam logic [CNT_W-1:0] PULSE_LAST   = CNT_W'(PULSE_UNITS * UNIT_TICKS - 1);
  localparam logic [CNT_W-1:0] RESTART_LAST = CNT_W'(RESTART_UNITS * UNIT_TICKS - 1);
  localparam logic [CNT_W-1:0] CYCLE_LAST   = CNT_W'(CYCLE_UNITS * UNIT_TICKS - 1);
  localparam logic [CNT_W-1:0] HALF_LAST    = CNT_W'((CYCLE_UNITS / 2) * UNIT_TICKS - 1);

  phase_t phase, phaseNext;
  logic   rstNext, wakeNext;
  logic   pulseDone, restartDone, cycleDone, halfDone;

  assign pulseDone   = tick && (count == PULSE_LAST);
  assign restartDone = tick && (count == RESTART_LAST);
  assign cycleDone   = tick && (count == CYCLE_LAST);
  assign halfDone    = tick && (count == HALF_LAST);

  always_comb begin
    phaseNext         = phase;
    rstNext           = rstOutN;
    wakeNext          = wakeOut;
    strobe            = '0;
    if (!supplyOk) begin
      phaseNext       = PH_HOLD;
      rstNext         = 1'b0;
      wakeNext        = 1'b0;
      strobe.clrTimer = 1'b1;
    end else begin
      unique case (phase)
        PH_HOLD: begin
          phaseNext       = PH_PULSE;
          strobe.clrTimer = 1'b1;
        end
        PH_PULSE: begin
          if (pulseDone) begin
            phaseNext       = PH_RESTART;
            rstNext         = 1'b1;
            strobe.clrTimer = 1'b1;
          end
        end
        PH_RESTART: begin
          if (restartDone) begin
            phaseNext         = PH_CYCLE;
            wakeNext          = 1'b1;
            strobe.clrTimer   = 1'b1;
            strobe.clrService = 1'b1;
          end
        end
        PH_CYCLE: begin
          if (cycleDone) begin
            strobe.clrTimer   = 1'b1;
            strobe.clrService = 1'b1;
            if (serviced || wdFall) begin
              wakeNext  = 1'b1;
            end else begin
              phaseNext = PH_PULSE;
              rstNext   = 1'b0;
              wakeNext  = 1'b0;
            end
          end else begin
            strobe.armService = 1'b1;
            if (wdFall && !serviced) wakeNext = 1'b0;
            if (halfDone)            wakeNext = 1'b0;
          end
        end
        default: phaseNext = PH_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      phase   <= PH_HOLD;
      rstOutN <= 1'b0;
      wakeOut <= 1'b0;
    end else begin
      phase   <= phaseNext;
      rstOutN <= rstNext;
      wakeOut <= wakeNext;
    end
  end

endmodule

// File: rtl/wakeWatchdogSeq.sv
module wakeWatchdogSeq
  import wws_pkg::*;
#(
  parameter int TICK_DIV   = 1000,
  parameter int UNIT_TICKS = 5
) (
  input  logic clk,
  input  logic porN,
  input  logic supplyOk,
  input  logic wdIn,
  output logic wakeOut,
  output logic rstOutN
);

  localparam int CNT_W = $clog2(CYCLE_UNITS * UNIT_TICKS);

  dpStrobe_t        strobe;
  logic             tick, wdFall, serviced;
  logic [CNT_W-1:0] count;

  wws_datapath #(.TICK_DIV(TICK_DIV), .UNIT_TICKS(UNIT_TICKS)) u_dp (
    .clk(clk), .porN(porN), .wdIn(wdIn), .strobe(strobe),
    .tick(tick), .count(count), .wdFall(wdFall), .serviced(serviced)
  );

  wws_control #(.TICK_DIV(TICK_DIV), .UNIT_TICKS(UNIT_TICKS)) u_ctl (
    .clk(clk), .porN(porN), .supplyOk(supplyOk), .tick(tick), .count(count),
    .wdFall(wdFall), .serviced(serviced), .strobe(strobe),
    .rstOutN(rstOutN), .wakeOut(wakeOut)
  );

endmodule

// File: rtl/wws_checker.sv
module wws_checker #(
  parameter int TICK_DIV   = 1000,
  parameter int UNIT_TICKS = 5
) (
  input logic clk,
  input logic porN,
  input logic supplyOk,
  input logic wdIn,
  input logic wakeOut,
  input logic rstOutN
);

  localparam int PULSE_CLKS = UNIT_TICKS * (TICK_DIV < 1 ? 1 : TICK_DIV);

  int lowRun;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                                 lowRun <= 0;
    else if (rstOutN)                          lowRun <= 0;
    else if (lowRun < PULSE_CLKS + 2)          lowRun <= lowRun + 1;
  end

  // R10: reset low always comes with wake-up low
  assert_wake_low_in_reset_R10: assert property (@(posedge clk) disable iff (!porN)
    !rstOutN |-> !wakeOut);

  // R2: a sampled supply drop forces reset at the next edge
  assert_supply_drop_R2: assert property (@(posedge clk) disable iff (!porN)
    !supplyOk |=> !rstOutN);

  // R4: wake-up only rises while reset has been released
  assert_wake_rise_after_release_R4: assert property (@(posedge clk) disable iff (!porN)
    $rose(wakeOut) |-> (rstOutN && $past(rstOutN)));

  // R3: every reset low interval lasts at least one pulse time
  assert_pulse_width_R3: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstOutN) |-> (lowRun >= PULSE_CLKS));

  // R1: reset release needs the supply to have been good at the previous edge
  assert_release_needs_supply_R1: assert property (@(posedge clk) disable iff (!porN)
    $rose(rstOutN) |-> $past(supplyOk));

  logic unusedWd;
  assign unusedWd = wdIn;

endmodule

bind wakeWatchdogSeq wws_checker #(.TICK_DIV(TICK_DIV), .UNIT_TICKS(UNIT_TICKS)) u_chk (
  .clk(clk), .porN(porN), .supplyOk(supplyOk), .wdIn(wdIn),
  .wakeOut(wakeOut), .rstOutN(rstOutN)
);

// File: tb/wakeWatchdogSeq_bench.sv
module wakeWatchdogSeq_bench;

  localparam int DIV  = 2;
  localparam int UNIT = 2;
  localparam int PULSE_C   = UNIT * DIV;
  localparam int RESTART_C = 4 * UNIT * DIV;
  localparam int CYCLE_C   = 8 * UNIT * DIV;
  localparam int HALF_C    = CYCLE_C / 2;

  logic clk = 1'b0;
  logic porN = 1'b0;
  logic supplyOk = 1'b0;
  logic wdIn = 1'b1;
  logic wakeOut, rstOutN;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  wakeWatchdogSeq #(.TICK_DIV(DIV), .UNIT_TICKS(UNIT)) u_wakeWatchdogSeq (
    .clk(clk), .porN(porN), .supplyOk(supplyOk), .wdIn(wdIn),
    .wakeOut(wakeOut), .rstOutN(rstOutN)
  );

  // clock-counting reference model built from the requirements
  typedef enum int {M_HOLD, M_PULSE, M_RESTART, M_CYCLE} mPhase_t;
  mPhase_t mPh;
  int      mCnt;
  logic    mServ, mWake, mRst;
  logic    m1, m2, m3;
  string   mTag;

  function automatic logic fallOf(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  always @(posedge clk or negedge porN) begin
    if (!porN) begin
      mPh <= M_HOLD; mCnt <= 0; mServ <= 1'b0; mWake <= 1'b0; mRst <= 1'b0;
      m1 <= 1'b1; m2 <= 1'b1; m3 <= 1'b1; mTag <= "R1";
    end else begin
      m1 <= wdIn; m2 <= m1; m3 <= m2;
      if (!supplyOk) begin
        mPh <= M_HOLD; mCnt <= 0; mRst <= 1'b0; mWake <= 1'b0;
        if (mPh != M_HOLD) mTag <= "R2";
      end else begin
        case (mPh)
          M_HOLD: begin mPh <= M_PULSE; mCnt <= 0; mTag <= "R3"; end
          M_PULSE:
            if (mCnt == PULSE_C - 1) begin
              mPh <= M_RESTART; mCnt <= 0; mRst <= 1'b1; mTag <= "R4";
            end else mCnt <= mCnt + 1;
          M_RESTART:
            if (mCnt == RESTART_C - 1) begin
              mPh <= M_CYCLE; mCnt <= 0; mWake <= 1'b1; mServ <= 1'b0; mTag <= "R5";
            end else mCnt <= mCnt + 1;
          default: begin
            if (mCnt == CYCLE_C - 1) begin
              mCnt <= 0; mServ <= 1'b0;
              if (mServ || fallOf(m3, m2)) begin
                mWake <= 1'b1; mTag <= "R5";
              end else begin
                mPh <= M_PULSE; mRst <= 1'b0; mWake <= 1'b0; mTag <= "R8";
              end
            end else begin
              mCnt <= mCnt + 1;
              if (fallOf(m3, m2) && !mServ) begin
                mServ <= 1'b1; mWake <= 1'b0; mTag <= "R6";
              end
              if (mCnt == HALF_C - 1) mWake <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp, input string what);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (porN && !done) begin
      check(mTag, rstOutN, mRst, "rstOutN vs model");
      check(mTag, wakeOut, mWake, "wakeOut vs model");
      if (!rstOutN) check("R10", wakeOut, 1'b0, "wake during reset");
    end
  end

  task automatic waitNeg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic waitWakeRise();
    @(negedge clk);
    while (!(wakeOut === 1'b1)) @(negedge clk);
  endtask

  task automatic waitRstRise();
    @(negedge clk);
    while (!(rstOutN === 1'b0)) @(negedge clk);
    while (!(rstOutN === 1'b1)) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired, actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state during power-on reset
    waitNeg(3);
    check("R1", rstOutN, 1'b0, "rst during por");
    check("R1", wakeOut, 1'b0, "wake during por");
    porN = 1'b1;
    waitNeg(10);
    check("R1", rstOutN, 1'b0, "rst held without supply");
    check("R1", wakeOut, 1'b0, "wake held without supply");

    // R3 / R4: release and restart timing from supply-good
    supplyOk = 1'b1;                 // first sampling edge is the next posedge
    waitNeg(PULSE_C);
    check("R3", rstOutN, 1'b0, "rst one clock before release");
    waitNeg(1);
    check("R3", rstOutN, 1'b1, "rst released");
    waitNeg(RESTART_C - 1);
    check("R4", wakeOut, 1'b0, "wake before restart delay end");
    waitNeg(1);
    check("R4", wakeOut, 1'b1, "wake rises after restart delay");

    // R5: first cycle unserviced in high half -> half high
    waitNeg(HALF_C - 1);
    check("R5", wakeOut, 1'b1, "wake high at end of high half");
    waitNeg(1);
    check("R5", wakeOut, 1'b0, "wake low in second half");
    waitNeg(2);
    wdIn = 1'b0; waitNeg(3); wdIn = 1'b1;   // service in low half
    waitWakeRise();

    // R6 / R7: latency of first edge, extra edges ignored
    waitNeg(3);
    wdIn = 1'b0;                         // at negedge 3 after rise
    waitNeg(2);
    check("R6", wakeOut, 1'b1, "wake before third edge");
    waitNeg(1);
    check("R6", wakeOut, 1'b0, "wake after third edge");
    waitNeg(2); wdIn = 1'b1;             // negedge 8
    waitNeg(4); wdIn = 1'b0;             // negedge 12, second edge
    waitNeg(2); wdIn = 1'b1;             // negedge 14
    waitNeg(CYCLE_C - 1 - 14);
    check("R7", wakeOut, 1'b0, "wake stays low after extra edges");
    waitNeg(1);
    check("R5", wakeOut, 1'b1, "next cycle starts after serviced cycle");

    // R9 / R8: edges during restart delay do not count, silent cycle resets
    waitRstRise();                       // this cycle is silent: reset follows
    waitNeg(2); wdIn = 1'b0; waitNeg(3); wdIn = 1'b1;  // negedges 2..5 of restart delay
    waitNeg(RESTART_C - 5);
    check("R4", wakeOut, 1'b1, "wake rises after restart delay again");
    waitNeg(CYCLE_C - 1);
    check("R9", rstOutN, 1'b1, "rst still high before silent cycle end");
    waitNeg(1);
    check("R8", rstOutN, 1'b0, "reset pulse after silent cycle");
    waitNeg(PULSE_C - 1);
    check("R8", rstOutN, 1'b0, "reset pulse still low");
    waitNeg(1);
    check("R8", rstOutN, 1'b1, "reset pulse ends");

    // R2: supply drop in the middle of a cycle
    waitWakeRise();
    waitNeg(5);
    supplyOk = 1'b0;
    waitNeg(1);
    check("R2", rstOutN, 1'b0, "rst after supply drop");
    check("R2", wakeOut, 1'b0, "wake after supply drop");
    waitNeg(4);
    supplyOk = 1'b1;

    // random mixture, compared with the model every clock
    for (int seg = 0; seg < 120; seg++) begin
      int kind = $urandom % 10;
      int len  = 10 + ($urandom % 50);
      if (kind == 0) begin
        supplyOk = 1'b0; waitNeg(1 + ($urandom % 5)); supplyOk = 1'b1;
      end else if (kind < 3) begin
        waitNeg(len);
      end else begin
        for (int i = 0; i < len; i++) begin
          if (($urandom % 6) == 0) wdIn = ~wdIn;
          waitNeg(1);
        end
      end
    end
    waitNeg(5);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule